// File: doc/BRIEF.md
# Burst Beat Address and Lane Sequencer

This block turns one accepted burst request into a stream of per-beat transfer descriptors. A request carries a start address, a length code (beats minus one), a size code (log2 of bytes per beat) and a burst kind. For every beat the block presents the transfer address and the byte lanes of the data bus that the beat may use. It presents one beat at a time, and it presents every beat of the burst. A data path beside it uses the descriptors to steer bytes in and out of a bus of `DATA_BYTES` lanes.

Both sides use valid/ready handshakes. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while no burst is in progress, so back-pressure on the request side lasts exactly as long as the burst. A beat transfers on an edge where `beat_valid` and `beat_ready` are both high. While `beat_ready` is low, the current beat stays on the outputs unchanged, with no limit on how long the stall lasts. `req_err` is a plain status pulse.

Size codes whose byte count is wider than the bus are outside the contract. Such a request is taken and dropped, and `req_err` reports it. The block does not check any other request field.

Top module: `burst_addr_gen`

## Requirements
- R1: After reset, `req_ready` is 1, `beat_valid` is 0 and `req_err` is 0.
- R2: `req_ready` is high exactly when no burst is active. A request transferred at a clock edge makes `beat_valid` high from that edge onward. `req_ready` stays low until the edge that consumes the last beat.
- R3: A request with length code L produces exactly L+1 beats. `beat_last` is 1 on beat L only, and the burst never ends early. `req_ready` returns high at the edge that consumes that beat.
- R4: Bytes per beat is 2 to the power of the size code (3-bit code: 0 means 1 byte, 7 means 128 bytes). Every beat after the first, in INCR and WRAP bursts, has an address that is a multiple of the byte count.
- R5: Burst code 2'b01 (INCR): beat 0 uses the raw start address. Beat n (n of 1 or more) uses the start address rounded down to the byte count, plus n times the byte count.
- R6: Burst code 2'b00 (FIXED): every beat carries the start address and the same lane mask.
- R7: Burst code 2'b10 (WRAP): the span is the byte count times (L+1). The lower bound is the start address rounded down to the span. Beat n uses lower bound + ((aligned start + n times byte count − lower bound) mod span), so the address returns to the lower bound when it would reach lower bound + span.
- R8: Lane mask (bit i is lane i): let o be the address modulo `DATA_BYTES`, and let w be o rounded down to the byte count. Lane i is active exactly when o ≤ i < w + byte count. An unaligned beat therefore loses the lanes below its offset, and lanes outside the size window are always off.
- R9: While `beat_valid` is 1 and `beat_ready` is 0, `beat_addr`, `beat_strb` and `beat_last` hold their values at the next edge.
- R10: A request with size code greater than log2(`DATA_BYTES`) transfers but produces no beats. `req_err` is 1 in the cycle after that request's edge, and `req_ready` stays 1.
- R11: Burst code 2'b11 is sequenced exactly like INCR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request may transfer (no burst active) |
| req_addr | input | ADDR_W | Start address |
| req_len | input | LEN_W | Beats minus one |
| req_size | input | 3 | log2 of bytes per beat |
| req_burst | input | 2 | Burst kind: 00 fixed, 01 incrementing, 10 wrapping, 11 treated as incrementing |
| beat_valid | output | 1 | Beat descriptor present |
| beat_ready | input | 1 | Consumer takes the beat |
| beat_addr | output | ADDR_W | Transfer address of the current beat |
| beat_strb | output | DATA_BYTES | Active byte lanes of the current beat |
| beat_last | output | 1 | Current beat is the final one |
| req_err | output | 1 | One-cycle pulse after an oversized request is dropped |

## Verification
A wrong remaining-beat count shows at the ports as `beat_last` appearing one beat early or late. It also shows as `req_ready` returning at the wrong edge, and that can be seen as soon as the last beat is consumed. A corrupted address register shows on `beat_addr` in the very next beat after the faulty step. Its low bits then show up again in `beat_strb`. Wrong wrap bounds only appear on the beat where the wrap should happen, so the sweep covers every wrapping length, and every size, at every lane offset of a small bus.

// File: rtl/bag_pkg.sv
package bag_pkg;
  typedef enum logic [1:0] {
    BURST_FIXED = 2'b00,
    BURST_INCR  = 2'b01,
    BURST_WRAP  = 2'b10,
    BURST_RSVD  = 2'b11
  } burst_e;
endpackage

// File: rtl/bag_step.sv
// Next-beat address: pure combinational, from current address and latched request.
module bag_step #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic [ADDR_W-1:0]   cur_addr,
  input  logic [ADDR_W-1:0]   start_addr,
  input  logic [LEN_W-1:0]    len,
  input  logic [2:0]          size,
  input  bag_pkg::burst_e     burst,
  output logic [ADDR_W-1:0]   nxt_addr
);
  import bag_pkg::*;

  logic [ADDR_W-1:0] step_bytes;
  logic [ADDR_W-1:0] stepped;
  logic [ADDR_W-1:0] span;
  logic [ADDR_W-1:0] lower;
  logic [ADDR_W-1:0] wrapped;

  always_comb begin
    step_bytes = ADDR_W'(1) << size;
    stepped    = (cur_addr & ~(step_bytes - ADDR_W'(1))) + step_bytes;
    span       = (ADDR_W'(len) + ADDR_W'(1)) << size;
    lower      = start_addr & ~(span - ADDR_W'(1));
    wrapped    = (stepped == lower + span) ? lower : stepped;
    unique case (burst)
      BURST_FIXED: nxt_addr = cur_addr;
      BURST_WRAP:  nxt_addr = wrapped;
      default:     nxt_addr = stepped;   // INCR and reserved code
    endcase
  end
endmodule

// File: rtl/bag_lanes.sv
// Byte-lane window for one beat, derived from the address low bits and size.
module bag_lanes #(
  parameter int DATA_BYTES = 8,
  localparam int LANE_W = $clog2(DATA_BYTES)
) (
  input  logic [LANE_W-1:0]     addr_lo,
  input  logic [2:0]            size,
  output logic [DATA_BYTES-1:0] strb
);
  logic [LANE_W:0] off;
  logic [LANE_W:0] win;
  logic [LANE_W:0] base;
  logic [LANE_W:0] top;

  always_comb begin
    off  = {1'b0, addr_lo};
    win  = (LANE_W+1)'(1) << size;
    base = off & ~(win - (LANE_W+1)'(1));
    top  = base + win;
  end

  for (genvar i = 0; i < DATA_BYTES; i++) begin : g_lane
    localparam logic [LANE_W:0] IDX = (LANE_W+1)'(i);
    assign strb[i] = (IDX >= off) && (IDX < top);
  end
endmodule

// File: rtl/bag_ctrl.sv
// Request capture, beat counter and burst state.
module bag_ctrl #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  parameter int LANE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [2:0]        req_size,
  input  logic [1:0]        req_burst,
  output logic              beat_valid,
  input  logic              beat_ready,
  output logic              beat_last,
  input  logic [ADDR_W-1:0] nxt_addr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [ADDR_W-1:0] st_addr,
  output logic [LEN_W-1:0]  st_len,
  output logic [2:0]        st_size,
  output bag_pkg::burst_e   st_burst,
  output logic              size_err
);
  import bag_pkg::*;

  localparam logic [3:0] MAX_SIZE = 4'(LANE_W);

  logic             busy_q;
  logic [LEN_W-1:0] left_q;
  logic             oversize;
  logic             accept;
  logic             fire;

  assign oversize = {1'b0, req_size} > MAX_SIZE;
  assign accept   = req_valid && !busy_q;
  assign fire     = busy_q && beat_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      left_q   <= '0;
      cur_addr <= '0;
      st_addr  <= '0;
      st_len   <= '0;
      st_size  <= '0;
      st_burst <= BURST_INCR;
      size_err <= 1'b0;
    end else begin
      size_err <= accept && oversize;
      if (accept && !oversize) begin
        busy_q   <= 1'b1;
        left_q   <= req_len;
        cur_addr <= req_addr;
        st_addr  <= req_addr;
        st_len   <= req_len;
        st_size  <= req_size;
        st_burst <= burst_e'(req_burst);
      end else if (fire) begin
        if (left_q == '0) begin
          busy_q <= 1'b0;
        end else begin
          left_q   <= left_q - LEN_W'(1);
          cur_addr <= nxt_addr;
        end
      end
    end
  end

  assign req_ready  = !busy_q;
  assign beat_valid = busy_q;
  assign beat_last  = busy_q && (left_q == '0);
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 8,
  parameter int DATA_BYTES = 8,
  localparam int LANE_W    = $clog2(DATA_BYTES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [LEN_W-1:0]      req_len,
  input  logic [2:0]            req_size,
  input  logic [1:0]            req_burst,
  output logic                  beat_valid,
  input  logic                  beat_ready,
  output logic [ADDR_W-1:0]     beat_addr,
  output logic [DATA_BYTES-1:0] beat_strb,
  output logic                  beat_last,
  output logic                  req_err
);
  logic [ADDR_W-1:0] nxt_addr;
  logic [ADDR_W-1:0] cur_addr;
  logic [ADDR_W-1:0] st_addr;
  logic [LEN_W-1:0]  st_len;
  logic [2:0]        st_size;
  bag_pkg::burst_e   st_burst;

  bag_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LANE_W(LANE_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .req_len    (req_len),
    .req_size   (req_size),
    .req_burst  (req_burst),
    .beat_valid (beat_valid),
    .beat_ready (beat_ready),
    .beat_last  (beat_last),
    .nxt_addr   (nxt_addr),
    .cur_addr   (cur_addr),
    .st_addr    (st_addr),
    .st_len     (st_len),
    .st_size    (st_size),
    .st_burst   (st_burst),
    .size_err   (req_err)
  );

  bag_step #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_step (
    .cur_addr   (cur_addr),
    .start_addr (st_addr),
    .len        (st_len),
    .size       (st_size),
    .burst      (st_burst),
    .nxt_addr   (nxt_addr)
  );

  bag_lanes #(.DATA_BYTES(DATA_BYTES)) u_lanes (
    .addr_lo (cur_addr[LANE_W-1:0]),
    .size    (st_size),
    .strb    (beat_strb)
  );

  assign beat_addr = cur_addr;
endmodule

// File: rtl/bag_chk.sv
module bag_chk #(
  parameter int ADDR_W     = 32,
  parameter int DATA_BYTES = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_ready,
  input logic                  beat_valid,
  input logic                  beat_ready,
  input logic [ADDR_W-1:0]     beat_addr,
  input logic [DATA_BYTES-1:0] beat_strb,
  input logic                  beat_last,
  input logic                  req_err,
  input logic [2:0]            st_size,
  input bag_pkg::burst_e       st_burst
);
  import bag_pkg::*;

  AST_READY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> !req_ready); // R2

  AST_LAST_IN_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |-> beat_valid); // R3

  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_ready && beat_last) |=> (req_ready && !beat_valid)); // R3

  AST_LATER_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_ready && !beat_last && st_burst != BURST_FIXED) |=>
      ((beat_addr & ((ADDR_W'(1) << st_size) - ADDR_W'(1))) == '0)); // R4

  AST_FIXED_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_ready && !beat_last && st_burst == BURST_FIXED) |=>
      ($stable(beat_addr) && $stable(beat_strb))); // R6

  AST_STRB_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> (beat_strb != '0)); // R8

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_ready) |=>
      (beat_valid && $stable(beat_addr) && $stable(beat_strb) && $stable(beat_last))); // R9

  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> (req_ready && !beat_valid)); // R10
endmodule

bind burst_addr_gen bag_chk #(.ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .beat_valid (beat_valid),
  .beat_ready (beat_ready),
  .beat_addr  (beat_addr),
  .beat_strb  (beat_strb),
  .beat_last  (beat_last),
  .req_err    (req_err),
  .st_size    (st_size),
  .st_burst   (st_burst)
);

// File: tb/sim_burst_addr_gen.sv
`timescale 1ns/1ps
module sim_burst_addr_gen;
  localparam int AW = 16;
  localparam int LW = 8;
  localparam int DB = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic [2:0]    req_size = '0;
  logic [1:0]    req_burst = '0;
  logic          beat_valid;
  logic          beat_ready = 1'b0;
  logic [AW-1:0] beat_addr;
  logic [DB-1:0] beat_strb;
  logic          beat_last;
  logic          req_err;

  int n_tests = 0;
  int n_fail  = 0;
  int stall_k = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .LEN_W(LW), .DATA_BYTES(DB)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_size(req_size), .req_burst(req_burst),
    .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_addr(beat_addr),
    .beat_strb(beat_strb), .beat_last(beat_last), .req_err(req_err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Reference address for beat n, computed directly (R5, R6, R7, R11).
  function automatic int ref_addr(int start, int sz, int len, int burst, int n);
    int bytes = 1 << sz;
    int al = start & ~(bytes - 1);
    int span = bytes * (len + 1);
    int lower = start & ~(span - 1);
    if (burst == 0 || n == 0) return start;
    if (burst == 2) return (lower + ((al + n * bytes - lower) % span)) & 16'hFFFF;
    return (al + n * bytes) & 16'hFFFF;
  endfunction

  // Reference lane mask (R8).
  function automatic int ref_strb(int addr, int sz);
    int bytes = 1 << sz;
    int o = addr % DB;
    int w = o & ~(bytes - 1);
    int m = 0;
    for (int i = 0; i < DB; i++)
      if (i >= o && i < w + bytes) m |= (1 << i);
    return m;
  endfunction

  task automatic run_burst(input int start, input int sz, input int len, input int burst);
    int prev_a;
    int prev_s;
    int prev_l;
    string tg;
    tg = (burst == 0) ? "R6" : (burst == 2) ? "R7" : (burst == 3) ? "R11" : "R5";
    chk("R2 idle ready", int'(req_ready), 1);
    req_valid = 1'b1; req_addr = AW'(start); req_len = LW'(len);
    req_size = 3'(sz); req_burst = 2'(burst);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 beat valid after accept", int'(beat_valid), 1);
    chk("R2 ready low while busy", int'(req_ready), 0);
    for (int n = 0; n <= len; n++) begin
      stall_k++;
      if (stall_k % 3 == 0) begin
        beat_ready = 1'b0;
        prev_a = int'(beat_addr); prev_s = int'(beat_strb); prev_l = int'(beat_last);
        @(negedge clk);
        chk("R9 stall addr", int'(beat_addr), prev_a);
        chk("R9 stall strb", int'(beat_strb), prev_s);
        chk("R9 stall last", int'(beat_last), prev_l);
      end
      beat_ready = 1'b1;
      chk({tg, " addr"}, int'(beat_addr), ref_addr(start, sz, len, burst, n));
      chk("R8 strb", int'(beat_strb), ref_strb(ref_addr(start, sz, len, burst, n), sz));
      chk("R3 last", int'(beat_last), (n == len) ? 1 : 0);
      chk("R3 valid", int'(beat_valid), 1);
      if (n > 0 && burst != 0)
        chk("R4 aligned", int'(beat_addr) % (1 << sz), 0);
      @(negedge clk);
      beat_ready = 1'b0;
    end
    chk("R3 no extra beat", int'(beat_valid), 0);
    chk("R3 ready back", int'(req_ready), 1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : stim
    int lens[6];
    lens = '{0, 1, 2, 3, 7, 15};
    repeat (3) @(negedge clk);
    chk("R1 reset ready", int'(req_ready), 1);
    chk("R1 reset valid", int'(beat_valid), 0);
    chk("R1 reset err", int'(req_err), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int b = 0; b < 4; b++)
      for (int s = 0; s <= 2; s++)
        for (int li = 0; li < 6; li++)
          for (int off = 0; off < 8; off++) begin
            if (b == 2 && (li == 0 || li == 2)) continue;   // wrap lengths 2,4,8,16
            if (b == 2 && (off % (1 << s)) != 0) continue;  // wrap starts size-aligned
            run_burst(16'h0120 + off, s, lens[li], b);
          end

    // Oversized requests (R10)
    for (int s = 3; s < 8; s++) begin
      req_valid = 1'b1; req_addr = 16'h0200; req_len = 8'd3;
      req_size = 3'(s); req_burst = 2'b01;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R10 err pulse", int'(req_err), 1);
      chk("R10 no beat", int'(beat_valid), 0);
      chk("R10 ready kept", int'(req_ready), 1);
      @(negedge clk);
      chk("R10 err clears", int'(req_err), 0);
      chk("R10 still no beat", int'(beat_valid), 0);
    end

    // Legal request right after an oversized one still runs (R10, R5)
    run_burst(16'h0FF6, 1, 4, 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule